// File: doc/BRIEF.md
# Serial Peripheral Shift Master

This block is an SPI master. A host controls it through a small register-style interface. The host writes a data byte while master mode is on, and the engine starts a full-duplex transfer at once. The transfer is 1 to 8 bits long. The engine drives SCK, shifts the frame out on MOSI with the most significant frame bit first, and collects the same number of bits from MISO. When the last clock period ends, the received bits go to a read buffer, right-aligned, and a sticky completion flag is raised. An interrupt request follows this flag while interrupts are enabled.

The engine uses a single clock mode. SCK rests low. MISO is captured on each rising SCK edge, and MOSI moves to the next bit on each falling edge. Each half of an SCK period lasts a programmable number of system clocks.

The engine also reports two faults. A data write that arrives while a transfer is running is dropped and raises a collision flag. A transfer that completes while the read buffer still holds unread data raises an overrun flag. In that case the old byte is kept and the new one is thrown away. The host clears any flag by writing a 0 to its bit.

Top module: `spi_shift_master`

## Requirements
- R1: A transfer starts on the clock edge that samples `wr_data` high, but only while `master_en` is 1 and no transfer is running. If `master_en` is 0, the write has no effect: busy, SCK and all flags stay unchanged.
- R2: A transfer shifts n = `frame_len`+1 bits, so `frame_len`=0 gives 1 bit and 7 gives 8 bits. MOSI carries `wdata[n-1]` first and `wdata[0]` last.
- R3: The n bits captured from MISO, in arrival order, form the low n bits of the received value, with the first bit as bit n-1. Bits 7..n read as 0.
- R4: SCK is low whenever the engine is idle. Each SCK half period lasts `half_div`+1 system clocks, so `busy` stays high for exactly 2·n·(`half_div`+1) clock cycles. MISO is sampled on rising SCK, and MOSI changes only on falling SCK.
- R5: On the edge where `busy` falls, `done_flag` (status bit 0) is set. If the buffer was free, `rdata` then shows the received value.
- R6: `irq` is 1 exactly when `done_flag` and `irq_en` are both 1.
- R7: A write to `wdata` while `busy` is 1 sets `wcol_flag` (status bit 1) on the next edge. The written byte is discarded, and the running transfer finishes with its original data and length.
- R8: Unread data is present when a buffered value has not yet been consumed by a `rd_data` strobe. If a transfer completes while unread data is present, `ovr_flag` (status bit 2) is set and `rdata` keeps the old value. A `rd_data` strobe on the completion edge itself counts as a read, so the new value is stored and no overrun occurs.
- R9: Flags are sticky. A `stat_wr` strobe clears every flag whose bit in `stat_wdata` is 0 and leaves flags whose bit is 1 unchanged. If a flag's set event occurs on the same edge as its clear, the flag ends up set.
- R10: After reset, `busy`, `sck`, `mosi`, `irq`, all flags and `rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en | input | 1 | Master mode enable |
| irq_en | input | 1 | Interrupt enable |
| frame_len | input | 3 | Frame length minus one |
| half_div | input | DIV_W | SCK half period minus one, in system clocks |
| wr_data | input | 1 | Data write strobe |
| wdata | input | 8 | Data to transmit |
| rd_data | input | 1 | Read strobe; consumes the buffered byte |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 3 | Status write value: {overrun, collision, done}; a 0 clears that flag |
| busy | output | 1 | Transfer in progress |
| rdata | output | 8 | Read buffer |
| done_flag | output | 1 | Transfer complete flag |
| wcol_flag | output | 1 | Write collision flag |
| ovr_flag | output | 1 | Receive overrun flag |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Two pairs of events can land on the same edge: the end of a transfer and a host flag clear, and the end of a transfer and a host read of the buffer. The bench knows the transfer length from R4. It places a clear-all status write on exactly the cycle in which `busy` falls, and it expects `done_flag` to still read 1 afterwards. In a separate transfer, it places a `rd_data` strobe on the completion edge while the buffer holds unread data, and it expects no overrun and the new value in `rdata`.

// File: rtl/spi_shift_master.sv
module spi_shift_master #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master_en,
  input  logic             irq_en,
  input  logic [2:0]       frame_len,
  input  logic [DIV_W-1:0] half_div,
  input  logic             wr_data,
  input  logic [7:0]       wdata,
  input  logic             rd_data,
  input  logic             stat_wr,
  input  logic [2:0]       stat_wdata,
  output logic             busy,
  output logic [7:0]       rdata,
  output logic             done_flag,
  output logic             wcol_flag,
  output logic             ovr_flag,
  output logic             irq,
  output logic             sck,
  output logic             mosi,
  input  logic             miso
);

  logic [DIV_W-1:0] cnt;
  logic [3:0]       left;
  logic [7:0]       sh, rx, rbuf;
  logic             full;

  wire [3:0] nbits  = {1'b0, frame_len} + 4'd1;
  wire       tick   = busy && (cnt == half_div);
  wire       rise   = tick && !sck;
  wire       fall   = tick && sck;
  wire       last   = fall && (left == 4'd0);
  wire       start  = wr_data && master_en && !busy;
  wire       unread = full && !rd_data;
  wire [2:0] keep   = stat_wr ? stat_wdata : 3'b111;

  assign mosi  = busy & sh[7];
  assign rdata = rbuf;
  assign irq   = irq_en & done_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sck  <= 1'b0;
      cnt  <= '0;
      left <= '0;
      sh   <= '0;
      rx   <= '0;
    end else if (start) begin
      busy <= 1'b1;
      sck  <= 1'b0;
      cnt  <= '0;
      left <= nbits;
      sh   <= wdata << (4'd8 - nbits);
      rx   <= '0;
    end else if (busy) begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (rise) begin
        sck  <= 1'b1;
        rx   <= {rx[6:0], miso};
        left <= left - 4'd1;
      end
      if (fall) begin
        sck <= 1'b0;
        sh  <= {sh[6:0], 1'b0};
        if (left == 4'd0) busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbuf      <= '0;
      full      <= 1'b0;
      done_flag <= 1'b0;
      wcol_flag <= 1'b0;
      ovr_flag  <= 1'b0;
    end else begin
      if (last && !unread) begin
        rbuf <= rx;
        full <= 1'b1;
      end else if (rd_data) begin
        full <= 1'b0;
      end
      done_flag <= last | (done_flag & keep[0]);
      wcol_flag <= (wr_data & busy) | (wcol_flag & keep[1]);
      ovr_flag  <= (last & unread) | (ovr_flag & keep[2]);
    end
  end

endmodule

// File: rtl/spi_shift_master_chk.sv
module spi_shift_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       master_en,
  input logic       wr_data,
  input logic       busy,
  input logic       sck,
  input logic       mosi,
  input logic       done_flag,
  input logic       wcol_flag,
  input logic       ovr_flag,
  input logic [7:0] rdata
);

  // R1
  start_needs_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(master_en && wr_data));

  // R4
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);

  // R4
  mosi_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && sck && $past(sck)) |-> $stable(mosi));

  // R5
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_flag);

  // R7
  wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_data) |=> wcol_flag);

  // R8
  ovr_keeps_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> $stable(rdata));

endmodule

bind spi_shift_master spi_shift_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .master_en(master_en), .wr_data(wr_data),
  .busy(busy), .sck(sck), .mosi(mosi), .done_flag(done_flag),
  .wcol_flag(wcol_flag), .ovr_flag(ovr_flag), .rdata(rdata)
);

// File: tb/spi_shift_master_tb.sv
module spi_shift_master_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       master_en = 1'b0, irq_en = 1'b0;
  logic [2:0] frame_len = '0;
  logic [7:0] half_div = '0;
  logic       wr_data = 1'b0, rd_data = 1'b0, stat_wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [2:0] stat_wdata = '0;
  logic       busy, done_flag, wcol_flag, ovr_flag, irq, sck, mosi;
  logic [7:0] rdata;
  logic [7:0] sl_sh = '0, sl_rx = '0;
  logic       miso;

  int n_chk = 0, n_bad = 0;

  typedef struct packed { logic [7:0] rd; logic [7:0] sl; logic [15:0] len; } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  spi_shift_master u_dut (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .irq_en(irq_en),
    .frame_len(frame_len), .half_div(half_div), .wr_data(wr_data),
    .wdata(wdata), .rd_data(rd_data), .stat_wr(stat_wr),
    .stat_wdata(stat_wdata), .busy(busy), .rdata(rdata),
    .done_flag(done_flag), .wcol_flag(wcol_flag), .ovr_flag(ovr_flag),
    .irq(irq), .sck(sck), .mosi(mosi), .miso(miso)
  );

  assign miso = sl_sh[7];
  always @(posedge sck) sl_rx <= {sl_rx[6:0], mosi};
  always @(negedge sck) sl_sh <= {sl_sh[6:0], 1'b0};

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  logic        prev_busy = 1'b0;
  logic [15:0] blen = '0;
  always @(negedge clk) begin
    if (busy) blen <= blen + 16'd1;
    if (prev_busy && !busy) begin
      if (sb.size() == 0) check("R1 unexpected end", 16'd1, 16'd0);
      else begin
        exp_t e;
        e = sb.pop_front();
        check("R3 rdata", {8'h0, rdata}, {8'h0, e.rd});
        check("R2 slave rx", {8'h0, sl_rx}, {8'h0, e.sl});
        check("R4 busy length", blen, e.len);
        check("R5 done", {15'h0, done_flag}, 16'd1);
      end
      blen <= '0;
    end
    prev_busy <= busy;
  end

  task automatic xfer(input logic [7:0] wd, input int n, input int d,
                      input logic [7:0] stx, input logic [7:0] exp_rd);
    exp_t e;
    e.rd  = exp_rd;
    e.sl  = wd & 8'((9'd1 << n) - 1);
    e.len = 16'(2 * n * (d + 1));
    sb.push_back(e);
    @(negedge clk);
    frame_len = 3'(n - 1);
    half_div  = 8'(d);
    sl_sh = stx;
    sl_rx = '0;
    wdata = wd;
    wr_data = 1'b1;
    @(negedge clk);
    wr_data = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic host_read();
    rd_data = 1'b1;
    @(negedge clk);
    rd_data = 1'b0;
  endtask

  task automatic clear_all();
    stat_wdata = 3'b000;
    stat_wr = 1'b1;
    @(negedge clk);
    stat_wr = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 busy", {15'h0, busy}, 16'd0);
    check("R10 sck/mosi", {14'h0, sck, mosi}, 16'd0);
    check("R10 flags", {13'h0, ovr_flag, wcol_flag, done_flag}, 16'd0);
    check("R10 rdata/irq", {7'h0, irq, rdata}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    master_en = 1'b1;
    irq_en = 1'b1;

    xfer(8'hA5, 8, 0, 8'h3C, 8'h3C);
    wait_idle();
    check("R6 irq set", {15'h0, irq}, 16'd1);
    host_read();
    clear_all();
    check("R9 done cleared", {15'h0, done_flag}, 16'd0);
    check("R6 irq cleared", {15'h0, irq}, 16'd0);

    irq_en = 1'b0;
    xfer(8'hF6, 3, 2, 8'hB7, 8'h05);
    wait_idle();
    check("R6 irq masked", {15'h0, irq}, 16'd0);
    host_read();
    clear_all();
    irq_en = 1'b1;

    xfer(8'h01, 1, 1, 8'h80, 8'h01);
    wait_idle();
    xfer(8'h55, 5, 0, 8'h00, 8'h01);
    wait_idle();
    check("R8 ovr set", {15'h0, ovr_flag}, 16'd1);
    check("R8 rdata kept", {8'h0, rdata}, 16'h0001);
    stat_wdata = 3'b011;
    stat_wr = 1'b1;
    @(negedge clk);
    stat_wr = 1'b0;
    check("R9 only ovr cleared", {13'h0, ovr_flag, wcol_flag, done_flag}, 16'b001);
    host_read();
    clear_all();

    xfer(8'hC3, 8, 1, 8'h5A, 8'h5A);
    repeat (3) @(negedge clk);
    wdata = 8'hFF;
    wr_data = 1'b1;
    @(negedge clk);
    wr_data = 1'b0;
    check("R7 wcol set", {15'h0, wcol_flag}, 16'd1);
    wait_idle();
    host_read();
    clear_all();
    check("R9 wcol cleared", {15'h0, wcol_flag}, 16'd0);

    master_en = 1'b0;
    @(negedge clk);
    wdata = 8'h99;
    wr_data = 1'b1;
    @(negedge clk);
    wr_data = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 ignored busy/sck", {14'h0, busy, sck}, 16'd0);
    check("R1 ignored flags", {13'h0, ovr_flag, wcol_flag, done_flag}, 16'd0);
    master_en = 1'b1;

    xfer(8'h0F, 4, 1, 8'hF0, 8'h0F);
    repeat (15) @(negedge clk);
    clear_all();
    check("R9 set wins over clear", {15'h0, done_flag}, 16'd1);
    wait_idle();
    clear_all();

    xfer(8'h81, 2, 0, 8'hC0, 8'h03);
    repeat (3) @(negedge clk);
    host_read();
    wait_idle();
    check("R8 read on end edge no ovr", {15'h0, ovr_flag}, 16'd0);
    check("R8 new value stored", {8'h0, rdata}, 16'h0003);
    check("R1 all ends seen", 16'(sb.size()), 16'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule